// File: doc/BRIEF.md
# SMBus Host Register Front End

This block is the byte-wide register front end of an SMBus host controller. Software reaches it through one-byte reads and writes to a small offset space. That space holds a status register, a control register, command, target address, two data bytes, a block data byte and an auxiliary control byte. The status bits clear when written with 1. The host-busy bit is the exception: software can never clear it by a write. A level interrupt is raised while interrupts are enabled and any status bit other than host busy is set.

The bus transaction engine sits outside this block and is reached through a simple handshake. The block pulses `xact_start` for one cycle and presents the protocol, target, command, write data and mode bits to the engine. The engine answers with `xact_done` or `xact_err`. A start written while interrupts are enabled launches at once. A start written with interrupts disabled only raises host busy and is held until software next reads the status register. A kill written to control abandons any operation and marks it failed. No launch happens while the device-error bit is set; the attempt leaves that bit set.

The control sequencer has four states:
- **IDLE**: nothing in flight.
- **HOLD**: a start is parked until the next status read.
- **LAUNCH**: a single cycle with `xact_start` high.
- **WAIT**: waiting for the engine.

The sequencer has these transitions:
- IDLE→LAUNCH: start written with the interrupt-enable bit set.
- IDLE→HOLD: start written with that bit clear.
- HOLD→LAUNCH: status read.
- HOLD→IDLE: status read while device error is set.
- IDLE→IDLE or HOLD→IDLE: a launch is blocked by device error.
- LAUNCH→WAIT: always, after one cycle.
- WAIT→IDLE: engine done or engine error.
- any→IDLE: kill.

Top module: `smbus_host_regs`

## Requirements
- R1: After reset the status register reads 0x00, the control register reads 0x00, `irq` is 0 and `xact_start` is 0.
- R2: A write to status (offset 0x0) clears every bit among 7:1 that is written as 1. Bit 0 (host busy) stays set whatever value is written.
- R3: Control (offset 0x2) has these fields: bit 0 interrupt enable, bit 1 kill, bits 4:2 protocol, bit 5 last byte, bit 6 start, bit 7 PEC enable. A control read returns only bits 4:0, with bits 7:5 reading 0.
- R4: Command (0x3), target address (0x4), data0 (0x5), data1 (0x6) and block data (0x7) read back the last byte written. Auxiliary control (0xD) keeps only bits 1:0 (bit 0 PEC, bit 1 block buffer).
- R5: Reads of any other offset return 0x00. Writes to any other offset change no register.
- R6: A control write with start=1, kill=0 and interrupt enable=1, while device error is clear and the sequencer is in IDLE or HOLD, drives `xact_start` high for exactly the following cycle. Status bit 0 then reads 1 until `xact_done`, which sets status bit 1 and clears bit 0.
- R7: A control write with start=1, kill=0 and interrupt enable=0 sets status bit 0 without raising `xact_start`. The next status read returns bit 0 as 1, and `xact_start` is high in the cycle after that read.
- R8: A control write with kill=1 sets status bit 4 (failed) and clears bit 0. No `xact_start` follows, even when start is written in the same byte.
- R9: `irq` is 1 exactly when control bit 0 is 1 and some status bit among 7:1 is 1. Host busy alone never raises it.
- R10: While status bit 2 (device error) is set, a launch attempt (an immediate start or a held start released by a status read) gives no `xact_start`, leaves bit 2 set and returns the sequencer to IDLE.
- R11: `xact_err` while waiting on the engine sets status bit 2 and clears bit 0.
- R12: While `xact_start` is high the engine sees the following:
  - `xact_proto` = control bits 4:2
  - `xact_target` = address register
  - `xact_cmd` = command register
  - `xact_wdata` = {data1, data0}
  - `xact_pec` = control bit 7 OR auxiliary bit 0
  - `xact_last` = control bit 5
  - `xact_blkbuf` = auxiliary bit 1

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W | Register offset of the access |
| wr_en | input | 1 | One-byte write strobe |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | One-byte read strobe |
| rd_data | output | 8 | Read byte, valid in the cycle of rd_en |
| irq | output | 1 | Level interrupt |
| xact_start | output | 1 | One-cycle launch pulse to the engine |
| xact_proto | output | 3 | Protocol selector |
| xact_target | output | 8 | Target address byte |
| xact_cmd | output | 8 | Command byte |
| xact_wdata | output | 16 | {data1, data0} |
| xact_pec | output | 1 | PEC requested |
| xact_last | output | 1 | Last-byte flag |
| xact_blkbuf | output | 1 | Block buffer mode |
| xact_done | input | 1 | Engine finished successfully |
| xact_err | input | 1 | Engine finished with device error |

## Verification
A sequencer stuck in or wrongly leaving HOLD or WAIT shows up on the next status read. Bit 0 reads with the wrong value, or `xact_start` appears or goes missing in the cycle right after that read. A corrupted sticky status bit shows on `irq` one cycle after the access that caused it, provided interrupts are enabled. It shows on the status byte at the next read in any case. The kill and device-error paths are observed at `xact_start` in the cycle after the control write, which is the earliest the pulse could appear.

// File: rtl/smbus_host_pkg.sv
package smbus_host_pkg;

    localparam int REG_ADDR_W = 4;
    localparam int NUM_REGS   = 8;

    // register index into the one-hot select vector
    localparam int IDX_STS = 0;
    localparam int IDX_CTL = 1;
    localparam int IDX_CMD = 2;
    localparam int IDX_ADR = 3;
    localparam int IDX_D0  = 4;
    localparam int IDX_D1  = 5;
    localparam int IDX_BLK = 6;
    localparam int IDX_AUX = 7;

    localparam logic [REG_ADDR_W-1:0] REG_OFFS [NUM_REGS] = '{
        4'h0, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7, 4'hD
    };

    // control field positions
    localparam int CTL_IEN   = 0;
    localparam int CTL_KILL  = 1;
    localparam int CTL_PLSB  = 2;
    localparam int CTL_LAST  = 5;
    localparam int CTL_START = 6;
    localparam int CTL_PEC   = 7;

    // status bit positions
    localparam int ST_BUSY   = 0;
    localparam int ST_DONE   = 1;
    localparam int ST_DEVERR = 2;
    localparam int ST_FAILED = 4;

    localparam int AUX_W = 2;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_HOLD   = 2'd1,
        S_LAUNCH = 2'd2,
        S_WAIT   = 2'd3
    } host_state_e;

endpackage

// File: rtl/smbus_reg_decode.sv
module smbus_reg_decode
    import smbus_host_pkg::*;
#(
    parameter int ADDR_W = REG_ADDR_W
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic [NUM_REGS-1:0] sel
);

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
        assign sel[i] = (addr == ADDR_W'(REG_OFFS[i]));
    end

endmodule

// File: rtl/smbus_status_bits.sv
module smbus_status_bits #(
    parameter int NBITS = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_we,
    input  logic [NBITS-1:0] clr_val,
    input  logic [NBITS-1:0] set_val,
    output logic [NBITS-1:0] bits_q
);

    for (genvar i = 0; i < NBITS; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bits_q[i] <= 1'b0;
            end else begin
                // a hardware set in the same cycle wins over a software clear
                bits_q[i] <= set_val[i] | (bits_q[i] & ~(clr_we & clr_val[i]));
            end
        end
    end

endmodule

// File: rtl/smbus_host_fsm.sv
module smbus_host_fsm
    import smbus_host_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_req,
    input  logic        kill_req,
    input  logic        ien_now,
    input  logic        sts_rd,
    input  logic        dev_err,
    input  logic        eng_done,
    input  logic        eng_err,
    output host_state_e state_q,
    output logic        busy,
    output logic        launch,
    output logic        block_evt,
    output logic        done_evt,
    output logic        err_evt,
    output logic        kill_evt
);

    host_state_e state_d;
    logic        attempt;

    // next-state
    always_comb begin
        state_d = state_q;
        attempt = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (start_req) begin
                    if (ien_now) begin
                        attempt = 1'b1;
                    end else begin
                        state_d = S_HOLD;
                    end
                end
            end
            S_HOLD: begin
                if (start_req) begin
                    if (ien_now) begin
                        attempt = 1'b1;
                    end
                end else if (sts_rd) begin
                    attempt = 1'b1;
                end
            end
            S_LAUNCH: state_d = S_WAIT;
            S_WAIT: begin
                if (eng_done || eng_err) begin
                    state_d = S_IDLE;
                end
            end
            default: state_d = S_IDLE;
        endcase
        if (attempt) begin
            state_d = dev_err ? S_IDLE : S_LAUNCH;
        end
        if (kill_req) begin
            state_d = S_IDLE;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs
    always_comb begin
        busy      = (state_q != S_IDLE);
        launch    = (state_q == S_LAUNCH);
        block_evt = attempt && dev_err && !kill_req;
        kill_evt  = kill_req;
        err_evt   = (state_q == S_WAIT) && eng_err && !kill_req;
        done_evt  = (state_q == S_WAIT) && eng_done && !eng_err && !kill_req;
    end

endmodule

// File: rtl/smbus_host_regs.sv
module smbus_host_regs
    import smbus_host_pkg::*;
#(
    parameter int ADDR_W = REG_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    input  logic              rd_en,
    output logic [7:0]        rd_data,
    output logic              irq,
    output logic              xact_start,
    output logic [2:0]        xact_proto,
    output logic [7:0]        xact_target,
    output logic [7:0]        xact_cmd,
    output logic [15:0]       xact_wdata,
    output logic              xact_pec,
    output logic              xact_last,
    output logic              xact_blkbuf,
    input  logic              xact_done,
    input  logic              xact_err
);

    localparam int STS_W = 8;
    localparam int STK_W = STS_W - 1;

    logic [NUM_REGS-1:0] sel;
    logic [4:0]          ctl_lo_q;
    logic                ctl_last_q;
    logic                ctl_pec_q;
    logic [7:0]          cmd_q, adr_q, d0_q, d1_q, blk_q;
    logic [AUX_W-1:0]    aux_q;
    logic [STK_W-1:0]    sticky_q;
    logic [STK_W-1:0]    set_val;
    logic [STS_W-1:0]    sts_view;
    logic                ctl_wr, sts_wr, sts_rd;
    logic                busy, launch, block_evt, done_evt, err_evt, kill_evt;
    host_state_e         state;

    smbus_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (reg_addr),
        .sel  (sel)
    );

    assign ctl_wr = wr_en && sel[IDX_CTL];
    assign sts_wr = wr_en && sel[IDX_STS];
    assign sts_rd = rd_en && !wr_en && sel[IDX_STS];

    smbus_host_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (ctl_wr && wr_data[CTL_START]),
        .kill_req  (ctl_wr && wr_data[CTL_KILL]),
        .ien_now   (wr_data[CTL_IEN]),
        .sts_rd    (sts_rd),
        .dev_err   (sticky_q[ST_DEVERR-1]),
        .eng_done  (xact_done),
        .eng_err   (xact_err),
        .state_q   (state),
        .busy      (busy),
        .launch    (launch),
        .block_evt (block_evt),
        .done_evt  (done_evt),
        .err_evt   (err_evt),
        .kill_evt  (kill_evt)
    );

    // hardware set requests for status bits 7:1 (index shifted by one)
    always_comb begin
        set_val                = '0;
        set_val[ST_DONE-1]     = done_evt;
        set_val[ST_DEVERR-1]   = err_evt | block_evt;
        set_val[ST_FAILED-1]   = kill_evt;
    end

    smbus_status_bits #(.NBITS(STK_W)) u_sts (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_we  (sts_wr),
        .clr_val (wr_data[STS_W-1:1]),
        .set_val (set_val),
        .bits_q  (sticky_q)
    );

    assign sts_view = {sticky_q, busy};

    // plain registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_lo_q   <= '0;
            ctl_last_q <= 1'b0;
            ctl_pec_q  <= 1'b0;
            cmd_q      <= '0;
            adr_q      <= '0;
            d0_q       <= '0;
            d1_q       <= '0;
            blk_q      <= '0;
            aux_q      <= '0;
        end else if (wr_en) begin
            if (sel[IDX_CTL]) begin
                ctl_lo_q   <= wr_data[4:0];
                ctl_last_q <= wr_data[CTL_LAST];
                ctl_pec_q  <= wr_data[CTL_PEC];
            end
            if (sel[IDX_CMD]) cmd_q <= wr_data;
            if (sel[IDX_ADR]) adr_q <= wr_data;
            if (sel[IDX_D0])  d0_q  <= wr_data;
            if (sel[IDX_D1])  d1_q  <= wr_data;
            if (sel[IDX_BLK]) blk_q <= wr_data;
            if (sel[IDX_AUX]) aux_q <= wr_data[AUX_W-1:0];
        end
    end

    // read mux: one-hot select, unmapped offsets give zero
    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            rd_data = ({8{sel[IDX_STS]}} & sts_view)
                    | ({8{sel[IDX_CTL]}} & {3'b000, ctl_lo_q})
                    | ({8{sel[IDX_CMD]}} & cmd_q)
                    | ({8{sel[IDX_ADR]}} & adr_q)
                    | ({8{sel[IDX_D0]}}  & d0_q)
                    | ({8{sel[IDX_D1]}}  & d1_q)
                    | ({8{sel[IDX_BLK]}} & blk_q)
                    | ({8{sel[IDX_AUX]}} & {{(8-AUX_W){1'b0}}, aux_q});
        end
    end

    assign irq         = ctl_lo_q[CTL_IEN] && (|sticky_q);
    assign xact_start  = launch;
    assign xact_proto  = ctl_lo_q[4:2];
    assign xact_target = adr_q;
    assign xact_cmd    = cmd_q;
    assign xact_wdata  = {d1_q, d0_q};
    assign xact_pec    = ctl_pec_q | aux_q[0];
    assign xact_last   = ctl_last_q;
    assign xact_blkbuf = aux_q[1];

endmodule

// File: rtl/smbus_host_checker.sv
module smbus_host_checker
    import smbus_host_pkg::*;
#(
    parameter int ADDR_W = REG_ADDR_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              wr_en,
    input logic              rd_en,
    input logic [7:0]        wr_data,
    input logic              xact_start,
    input logic              xact_done,
    input logic              irq,
    input logic              busy,
    input logic              ien,
    input logic              dev_err,
    input host_state_e       state
);

    logic ctl_acc, sts_acc;
    assign ctl_acc = wr_en && (reg_addr == ADDR_W'(REG_OFFS[IDX_CTL]));
    assign sts_acc = (wr_en || rd_en) && (reg_addr == ADDR_W'(REG_OFFS[IDX_STS]));

    p_start_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        xact_start |=> !xact_start);

    p_done_frees_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT && xact_done && !ctl_acc) |=> !busy);

    p_hold_waits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ctl_acc && !sts_acc) |=> !xact_start);

    p_busy_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_HOLD && wr_en && !ctl_acc) |=> busy);

    p_kill_idles_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_acc && wr_data[CTL_KILL]) |=> (!busy && !xact_start));

    p_deverr_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_acc && dev_err) |=> !xact_start);

    p_irq_needs_ien_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ien);

    p_busy_no_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !dev_err && !irq) |=> $stable(irq) || ctl_acc || sts_acc || xact_done || !busy || $past(xact_done) == 1'b0);

endmodule

bind smbus_host_regs smbus_host_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_addr   (reg_addr),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .wr_data    (wr_data),
    .xact_start (xact_start),
    .xact_done  (xact_done),
    .irq        (irq),
    .busy       (busy),
    .ien        (ctl_lo_q[0]),
    .dev_err    (sticky_q[1]),
    .state      (state)
);

// File: tb/tb_smbus_host_regs.sv
module tb_smbus_host_regs;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_data;
    logic        irq, xact_start, xact_pec, xact_last, xact_blkbuf;
    logic [2:0]  xact_proto;
    logic [7:0]  xact_target, xact_cmd;
    logic [15:0] xact_wdata;
    logic        xact_done = 1'b0;
    logic        xact_err = 1'b0;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    smbus_host_regs dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .irq(irq),
        .xact_start(xact_start), .xact_proto(xact_proto),
        .xact_target(xact_target), .xact_cmd(xact_cmd),
        .xact_wdata(xact_wdata), .xact_pec(xact_pec), .xact_last(xact_last),
        .xact_blkbuf(xact_blkbuf), .xact_done(xact_done), .xact_err(xact_err)
    );

    // {is_read, offset, byte (write value or expected read), requirement}
    localparam logic [16:0] VEC [NVEC] = '{
        {1'b0, 4'h3, 8'hA5, 4'd4},   // R4 command
        {1'b1, 4'h3, 8'hA5, 4'd4},
        {1'b0, 4'h4, 8'h3C, 4'd4},   // R4 address
        {1'b1, 4'h4, 8'h3C, 4'd4},
        {1'b0, 4'h5, 8'h34, 4'd4},   // R4 data0
        {1'b1, 4'h5, 8'h34, 4'd4},
        {1'b0, 4'h6, 8'h12, 4'd4},   // R4 data1
        {1'b1, 4'h6, 8'h12, 4'd4},
        {1'b0, 4'h7, 8'h99, 4'd4},   // R4 block data
        {1'b1, 4'h7, 8'h99, 4'd4},
        {1'b0, 4'hD, 8'hFE, 4'd4},   // R4 aux keeps bits 1:0
        {1'b1, 4'hD, 8'h02, 4'd4},
        {1'b0, 4'h2, 8'hBC, 4'd3},   // R3 control, no start, no kill
        {1'b1, 4'h2, 8'h1C, 4'd3},
        {1'b0, 4'h1, 8'h77, 4'd5},   // R5 unmapped
        {1'b1, 4'h1, 8'h00, 4'd5},
        {1'b0, 4'h8, 8'h55, 4'd5},
        {1'b1, 4'h8, 8'h00, 4'd5},
        {1'b1, 4'h3, 8'hA5, 4'd5},   // R5 mapped regs untouched
        {1'b1, 4'h7, 8'h99, 4'd5}
    };

    task automatic check(input int req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; rd_en = 1'b1;
        #1 d = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse(input bit is_err);
        @(negedge clk);
        if (is_err) xact_err = 1'b1; else xact_done = 1'b1;
        @(negedge clk);
        xact_err = 1'b0; xact_done = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check(1, {15'b0, irq}, 16'h0);
        check(1, {15'b0, xact_start}, 16'h0);
        do_read(4'h0, r); check(1, {8'h0, r}, 16'h0000);
        do_read(4'h2, r); check(1, {8'h0, r}, 16'h0000);

        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][16]) begin
                do_read(VEC[i][15:12], r);
                check(int'(VEC[i][3:0]), {8'h0, r}, {8'h0, VEC[i][11:4]});
            end else begin
                do_write(VEC[i][15:12], VEC[i][11:4]);
            end
        end

        // R6 / R12 immediate launch: pec, start, proto 1, ien
        do_write(4'h2, 8'hC5);
        check(6, {15'b0, xact_start}, 16'h1);
        check(12, {13'b0, xact_proto}, 16'h1);
        check(12, {8'h0, xact_target}, 16'h003C);
        check(12, {8'h0, xact_cmd}, 16'h00A5);
        check(12, xact_wdata, 16'h1234);
        check(12, {13'b0, xact_pec, xact_last, xact_blkbuf}, 16'h5);
        do_read(4'h2, r); check(3, {8'h0, r}, 16'h0005);  // R3 start reads 0
        do_read(4'h0, r); check(6, {8'h0, r}, 16'h0001);
        check(6, {15'b0, xact_start}, 16'h0);
        check(9, {15'b0, irq}, 16'h0);                    // R9 busy alone
        pulse(1'b0);
        do_read(4'h0, r); check(6, {8'h0, r}, 16'h0002);
        check(9, {15'b0, irq}, 16'h1);
        do_write(4'h0, 8'h02);
        check(9, {15'b0, irq}, 16'h0);
        do_read(4'h0, r); check(2, {8'h0, r}, 16'h0000);

        // R7 deferred start, R2 busy not clearable
        do_write(4'h2, 8'h40);
        check(7, {15'b0, xact_start}, 16'h0);
        repeat (3) @(negedge clk);
        check(7, {15'b0, xact_start}, 16'h0);
        do_write(4'h0, 8'hFF);
        check(7, {15'b0, xact_start}, 16'h0);
        do_read(4'h0, r); check(2, {8'h0, r}, 16'h0001);
        check(7, {15'b0, xact_start}, 16'h1);
        pulse(1'b0);
        do_read(4'h0, r); check(7, {8'h0, r}, 16'h0002);
        check(9, {15'b0, irq}, 16'h0);                    // R9 ien clear
        do_write(4'h0, 8'h02);

        // R8 kill during wait
        do_write(4'h2, 8'h41);
        check(6, {15'b0, xact_start}, 16'h1);
        do_write(4'h2, 8'h03);
        check(8, {15'b0, xact_start}, 16'h0);
        do_read(4'h0, r); check(8, {8'h0, r}, 16'h0010);
        check(9, {15'b0, irq}, 16'h1);
        do_write(4'h0, 8'h10);
        // R8 kill with start in the same byte
        do_write(4'h2, 8'h42);
        check(8, {15'b0, xact_start}, 16'h0);
        do_read(4'h0, r); check(8, {8'h0, r}, 16'h0010);
        check(8, {15'b0, xact_start}, 16'h0);
        do_write(4'h0, 8'h10);

        // R11 engine error
        do_write(4'h2, 8'h41);
        pulse(1'b1);
        do_read(4'h0, r); check(11, {8'h0, r}, 16'h0004);

        // R10 launch blocked by device error
        do_write(4'h2, 8'h41);
        check(10, {15'b0, xact_start}, 16'h0);
        do_read(4'h0, r); check(10, {8'h0, r}, 16'h0004);
        do_write(4'h2, 8'h40);
        do_read(4'h0, r); check(10, {8'h0, r}, 16'h0005);
        check(10, {15'b0, xact_start}, 16'h0);
        do_read(4'h0, r); check(10, {8'h0, r}, 16'h0004);
        do_write(4'h0, 8'h04);
        do_read(4'h0, r); check(2, {8'h0, r}, 16'h0000);

        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule